// File: doc/BRIEF.md
# Multi-level priority interrupt arbiter

This block holds pending interrupt requests on eight priority levels, each level a register of up to 32 request bits. It compares them with the processor's current priority and raises a pending flag whenever some request could be taken. When the processor strobes acknowledge, the block selects one winner, clears that request bit and, one cycle later, returns the winner's level and bit index. The processor uses that pair to look up a vector.

On each level, bit 0 is the software-generated request. On level 6, bit 1 is the timer-tick request. These bits, and nothing else, are the internal sources.

A bus-mode input chooses between two kinds of system. On a multi-level device bus, every request bit can win. On a single-level device bus, devices cannot interrupt while the processor runs at priority 4 or above. Only internal sources compete then. Device requests are not lost: they stay stored until the priority falls below 4.

Top module: `irq_level_arbiter`

## Requirements
- R1: After a synchronous reset all request registers are clear, `irq_pending_o` is 0 and `ack_valid_o` is 0.
- R2: Only levels strictly greater than `cur_pri_i` are considered. Level 0 can never win.
- R3: Among eligible levels, the highest-numbered level wins.
- R4: Within the winning level, the lowest-numbered eligible bit wins. Bit 0 of levels 1 to 7 is the software request. Bit 1 of level 6 is the timer request, second after bit 0.
- R5: With `bus_single_i`=1 and `cur_pri_i` >= 4, only internal bits can win: bit 0 on levels 1 to 7, and bits 0 and 1 on level 6. Other bits neither raise `irq_pending_o` nor win, but they stay stored.
- R6: With `bus_single_i`=0, or with `cur_pri_i` < 4, every stored bit on a level above `cur_pri_i` is eligible.
- R7: An `ack_i` while `irq_pending_o`=1 clears the winning bit. In the next cycle, `ack_valid_o`=1 with `ack_lvl_o` and `ack_bit_o` naming the winner.
- R8: An `ack_i` while `irq_pending_o`=0 yields `ack_valid_o`=0 in the next cycle and leaves every request bit unchanged.
- R9: If a set pulse and an acknowledge-clear hit the same bit in the same cycle, the bit stays set.
- R10: Bit `l*32+b` of `set_req_i` sets bit b of level l for one cycle. Set pulses are ORed into the stored bits, and bit 31 of each level is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_single_i | input | 1 | 1 = single-level device bus, 0 = multi-level device bus |
| cur_pri_i | input | 3 | Current processor priority |
| set_req_i | input | 256 | One-cycle set pulses; bit l*32+b sets bit b of level l |
| ack_i | input | 1 | Acknowledge strobe |
| irq_pending_o | output | 1 | Some request is eligible (combinational) |
| ack_valid_o | output | 1 | Registered: the last acknowledge found a winner |
| ack_lvl_o | output | 3 | Registered winning level |
| ack_bit_o | output | 5 | Registered winning bit index |

## Verification
The hardest case is a device request that is hidden in single-level mode and must come back unchanged later. To reach it, the stimulus loads device bits at levels 5 and 6 while the priority sits at 4 in single-level mode. It then shows that acknowledges return only the internal winners. Finally it lowers the priority to 3 and drains the hidden bits in level order. The same-cycle set/clear collision is reached by issuing a set pulse in the same cycle as the acknowledge that takes that bit. The bench then acknowledges again and expects the same winner.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Bus mode encoding for bus_single_i
  typedef enum logic {
    BUS_MULTI  = 1'b0,
    BUS_SINGLE = 1'b1
  } bus_mode_e;

  // Internal-source bits of a level: none on level 0, the software bit on
  // every other level, plus the timer bit on the timer level.
  function automatic int unsigned internal_bits(int lvl, int clk_lvl);
    if (lvl == 0) return 0;
    if (lvl == clk_lvl) return 3;
    return 1;
  endfunction

endpackage

// File: rtl/irq_lvl_filter.sv
module irq_lvl_filter #(
  parameter int REQ_W   = 32,
  parameter int LVL_W   = 3,
  parameter int LVL_IDX = 0,
  parameter logic [REQ_W-1:0] IMASK = '0
) (
  input  logic [REQ_W-1:0] req_i,
  input  logic [LVL_W-1:0] cur_pri_i,
  input  logic             open_all_i,
  output logic [REQ_W-1:0] masked_o,
  output logic             elig_o
);
  logic above;

  always_comb begin
    above    = LVL_W'(LVL_IDX) > cur_pri_i;
    masked_o = above ? (open_all_i ? req_i : (req_i & IMASK)) : '0;
    elig_o   = |masked_o;
  end
endmodule

// File: rtl/irq_lvl_select.sv
module irq_lvl_select #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] elig_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    any_o = |elig_i;
    lvl_o = '0;
    // ascending scan: the last hit is the highest level
    for (int l = 0; l < NUM_LVL; l++) begin
      if (elig_i[l]) lvl_o = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int REQ_W = 32,
  parameter int BIT_W = 5
) (
  input  logic [REQ_W-1:0] vec_i,
  output logic             found_o,
  output logic [BIT_W-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    // descending scan: the last hit is the lowest bit
    for (int b = REQ_W - 1; b >= 0; b--) begin
      if (vec_i[b]) idx_o = BIT_W'(b);
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LVL   = 8,
  parameter int REQ_W     = 32,
  parameter int CLK_LVL   = 6,
  parameter int SPLIT_PRI = 4,
  localparam int LVL_W    = $clog2(NUM_LVL),
  localparam int BIT_W    = $clog2(REQ_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_single_i,
  input  logic [LVL_W-1:0]         cur_pri_i,
  input  logic [NUM_LVL*REQ_W-1:0] set_req_i,
  input  logic                     ack_i,
  output logic                     irq_pending_o,
  output logic                     ack_valid_o,
  output logic [LVL_W-1:0]         ack_lvl_o,
  output logic [BIT_W-1:0]         ack_bit_o
);
  logic [NUM_LVL-1:0][REQ_W-1:0] req_q;
  logic [NUM_LVL-1:0][REQ_W-1:0] masked;
  logic [NUM_LVL-1:0][REQ_W-1:0] set_vec;
  logic [NUM_LVL-1:0]            elig;
  logic                          open_all;
  logic                          any_elig;
  logic [LVL_W-1:0]              win_lvl;
  logic [REQ_W-1:0]              win_vec;
  logic                          win_found;
  logic [BIT_W-1:0]              win_bit;
  logic                          take;
  logic [REQ_W-1:0]              clr_vec;

  assign set_vec  = set_req_i;
  assign open_all = (bus_mode_e'(bus_single_i) == BUS_MULTI) ||
                    (cur_pri_i < LVL_W'(SPLIT_PRI));

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      localparam logic [REQ_W-1:0] IMASK = REQ_W'(internal_bits(l, CLK_LVL));
      irq_lvl_filter #(
        .REQ_W(REQ_W), .LVL_W(LVL_W), .LVL_IDX(l), .IMASK(IMASK)
      ) u_filter (
        .req_i      (req_q[l]),
        .cur_pri_i  (cur_pri_i),
        .open_all_i (open_all),
        .masked_o   (masked[l]),
        .elig_o     (elig[l])
      );
    end
  endgenerate

  irq_lvl_select #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_lvl_sel (
    .elig_i (elig),
    .any_o  (any_elig),
    .lvl_o  (win_lvl)
  );

  assign win_vec = masked[win_lvl];

  irq_lsb_pick #(.REQ_W(REQ_W), .BIT_W(BIT_W)) u_bit_pick (
    .vec_i   (win_vec),
    .found_o (win_found),
    .idx_o   (win_bit)
  );

  assign irq_pending_o = any_elig;
  assign take          = ack_i && any_elig && win_found;
  assign clr_vec       = take ? (REQ_W'(1) << win_bit) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else begin
      for (int l = 0; l < NUM_LVL; l++) begin
        if (LVL_W'(l) == win_lvl)
          req_q[l] <= (req_q[l] & ~clr_vec) | set_vec[l];
        else
          req_q[l] <= req_q[l] | set_vec[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid_o <= 1'b0;
      ack_lvl_o   <= '0;
      ack_bit_o   <= '0;
    end else begin
      ack_valid_o <= take;
      if (take) begin
        ack_lvl_o <= win_lvl;
        ack_bit_o <= win_bit;
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int LVL_W     = 3,
  parameter int BIT_W     = 5,
  parameter int CLK_LVL   = 6,
  parameter int SPLIT_PRI = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_single_i,
  input logic [LVL_W-1:0] cur_pri_i,
  input logic             ack_i,
  input logic             irq_pending_o,
  input logic             ack_valid_o,
  input logic [LVL_W-1:0] ack_lvl_o,
  input logic [BIT_W-1:0] ack_bit_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !ack_valid_o); // R1

  AST_WIN_ABOVE_PRI: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (ack_lvl_o > $past(cur_pri_i))); // R2

  AST_INTERNAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ack_valid_o && $past(bus_single_i && (cur_pri_i >= LVL_W'(SPLIT_PRI))))
      |-> (ack_bit_o == '0 ||
           (ack_bit_o == BIT_W'(1) && ack_lvl_o == LVL_W'(CLK_LVL)))); // R5

  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_pending_o) |=> ack_valid_o); // R7

  AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !irq_pending_o) |=> !ack_valid_o); // R8

  AST_NO_ACK_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !ack_valid_o); // R7
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .LVL_W(LVL_W), .BIT_W(BIT_W), .CLK_LVL(CLK_LVL), .SPLIT_PRI(SPLIT_PRI)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_single_i  (bus_single_i),
  .cur_pri_i     (cur_pri_i),
  .ack_i         (ack_i),
  .irq_pending_o (irq_pending_o),
  .ack_valid_o   (ack_valid_o),
  .ack_lvl_o     (ack_lvl_o),
  .ack_bit_o     (ack_bit_o)
);

// File: tb/irq_level_arbiter_tb_top.sv
module irq_level_arbiter_tb_top;
  localparam int NUM_LVL = 8;
  localparam int REQ_W   = 32;

  logic                     clk = 1'b0;
  logic                     rst;
  logic                     bus_single_i;
  logic [2:0]               cur_pri_i;
  logic [NUM_LVL*REQ_W-1:0] set_req_i;
  logic                     ack_i;
  logic                     irq_pending_o;
  logic                     ack_valid_o;
  logic [2:0]               ack_lvl_o;
  logic [4:0]               ack_bit_o;

  int checks   = 0;
  int failures = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       ack_d = 1'b0;

  always #5 clk = ~clk;

  irq_level_arbiter dut_i (
    .clk(clk), .rst(rst), .bus_single_i(bus_single_i), .cur_pri_i(cur_pri_i),
    .set_req_i(set_req_i), .ack_i(ack_i), .irq_pending_o(irq_pending_o),
    .ack_valid_o(ack_valid_o), .ack_lvl_o(ack_lvl_o), .ack_bit_o(ack_bit_o)
  );

  always @(posedge clk) ack_d <= ack_i;

  // Monitor: one expected item per acknowledge, compared a half cycle after
  // the edge that registers the result.
  always @(negedge clk) begin
    if (!rst && ack_d) begin
      logic [8:0] e;
      string      t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected result valid=%0d expected none", ack_valid_o);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (ack_valid_o !== e[8] ||
            (e[8] && (ack_lvl_o !== e[7:5] || ack_bit_o !== e[4:0]))) begin
          failures++;
          $display("FAIL %s actual v=%0d l=%0d b=%0d expected v=%0d l=%0d b=%0d",
                   t, ack_valid_o, ack_lvl_o, ack_bit_o, e[8], e[7:5], e[4:0]);
        end
      end
    end
  end

  task automatic check_pend(input logic exp, input string tag);
    checks++;
    if (irq_pending_o !== exp) begin
      failures++;
      $display("FAIL %s pending actual=%0d expected=%0d", tag, irq_pending_o, exp);
    end
  endtask

  task automatic set_bit(input int l, input int b);
    set_req_i[l*REQ_W + b] = 1'b1;
  endtask

  task automatic expect_ack(input logic v, input int l, input int b, input string tag);
    ack_i = 1'b1;
    exp_q.push_back({v, 3'(l), 5'(b)});
    tag_q.push_back(tag);
  endtask

  task automatic step();
    @(negedge clk);
    set_req_i = '0;
    ack_i     = 1'b0;
  endtask

  initial begin
    rst = 1'b1; bus_single_i = 1'b0; cur_pri_i = 3'd0; set_req_i = '0; ack_i = 1'b0;
    repeat (3) @(negedge clk);
    check_pend(1'b0, "R1");
    checks++;
    if (ack_valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 valid actual=%0d expected=0", ack_valid_o);
    end
    rst = 1'b0;
    step();
    // R8: empty acknowledge
    expect_ack(1'b0, 0, 0, "R8 empty"); step();
    // R2: level 0 never eligible
    set_bit(0, 0); step();
    check_pend(1'b0, "R2 level0");
    expect_ack(1'b0, 0, 0, "R2 level0 ack"); step();
    // R3 / R6: multi mode ordering
    set_bit(5, 3); set_bit(5, 7); set_bit(4, 1); step();
    check_pend(1'b1, "R6 pend");
    expect_ack(1'b1, 5, 3, "R3 first"); step();
    expect_ack(1'b1, 5, 7, "R4 second"); step();
    expect_ack(1'b1, 4, 1, "R3 third"); step();
    expect_ack(1'b0, 0, 0, "R7 drained"); step();
    // R4: level 6 software, timer, device order
    set_bit(6, 2); set_bit(6, 1); set_bit(6, 0); step();
    expect_ack(1'b1, 6, 0, "R4 sw"); step();
    expect_ack(1'b1, 6, 1, "R4 clk"); step();
    expect_ack(1'b1, 6, 2, "R4 dev"); step();
    // R2: threshold
    set_bit(3, 2); cur_pri_i = 3'd3; step();
    check_pend(1'b0, "R2 at pri");
    expect_ack(1'b0, 0, 0, "R2 hidden ack"); step();
    cur_pri_i = 3'd2; #1;
    check_pend(1'b1, "R2 below pri");
    expect_ack(1'b1, 3, 2, "R2 taken"); step();
    // R5: single-level mode hides devices
    bus_single_i = 1'b1; cur_pri_i = 3'd4;
    set_bit(6, 5); set_bit(5, 4); set_bit(7, 3); step();
    check_pend(1'b0, "R5 hidden");
    expect_ack(1'b0, 0, 0, "R5 hidden ack"); step();
    set_bit(6, 1); step();
    expect_ack(1'b1, 6, 1, "R5 clk wins"); step();
    set_bit(5, 0); step();
    expect_ack(1'b1, 5, 0, "R5 sw wins"); step();
    check_pend(1'b0, "R5 hidden again");
    // R6: drop below split, stored devices return
    cur_pri_i = 3'd3; #1;
    check_pend(1'b1, "R6 revealed");
    expect_ack(1'b1, 7, 3, "R6 l7"); step();
    expect_ack(1'b1, 6, 5, "R6 l6"); step();
    expect_ack(1'b1, 5, 4, "R6 l5"); step();
    // R9: collision keeps bit
    bus_single_i = 1'b0; cur_pri_i = 3'd0;
    set_bit(2, 0); step();
    set_bit(2, 0); expect_ack(1'b1, 2, 0, "R9 take"); step();
    expect_ack(1'b1, 2, 0, "R9 kept"); step();
    expect_ack(1'b0, 0, 0, "R9 gone"); step();
    // R10: top bit, OR accumulation
    set_bit(1, 31); step();
    set_bit(1, 30); step();
    expect_ack(1'b1, 1, 30, "R10 or"); step();
    expect_ack(1'b1, 1, 31, "R10 bit31"); step();
    step(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule